// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address for every beat of a four-beat burst. A start strobe captures the full starting address. Two strobes can start a burst: one driven by the processor and one by the memory controller. From then on, each asserted advance moves the low two address bits to the next beat. The upper address bits stay frozen at the captured value.

The low bits follow one of two wraparound orders, and a static order-select input picks which one. The linear order counts upward modulo four. The interleaved order XORs the starting beat with a running beat count. Both orders work from any starting beat. After four advances the sequence returns to the starting beat of the same four-beat group.

The output is taken from registers only, so a load or an advance shows on `addr_o` one clock after the edge that samples it.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first load, `addr_o` reads zero.
- R2: When `ld_cpu_i` is high at a rising edge, `addr_o` equals the `addr_i` value sampled at that edge, starting in the next cycle.
- R3: When `ld_ctl_i` is high at a rising edge, `addr_o` equals the sampled `addr_i`, starting in the next cycle.
- R4: With `order_i` = 0 (linear), each advance sets the low two bits to (previous + 1) mod 4. A start of 2 gives 2,3,0,1.
- R5: With `order_i` = 1 (interleaved), the low two bits equal the start bits XOR a beat count that runs 0,1,2,3. A start of 1 gives 1,0,3,2, and a start of 2 gives 2,3,0,1.
- R6: An advance never changes `addr_o[ADDR_W-1:2]`.
- R7: A cycle with no strobe and no advance leaves `addr_o` unchanged.
- R8: The fifth address of a burst, reached after four advances, equals the starting address. Later advances repeat the same four-beat group.
- R9: A load strobe overrides `adv_i` in the same cycle. The loaded address appears unchanged.
- R10: When both load strobes are high at once, the block performs a single load of `addr_i`.
- R11: `order_i` is a static strap and is changed only between bursts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_cpu_i | input | 1 | Processor-side burst start strobe, active high |
| ld_ctl_i | input | 1 | Controller-side burst start strobe, active high |
| adv_i | input | 1 | Move to the next beat, active high |
| order_i | input | 1 | Order strap: 0 = linear, 1 = interleaved |
| addr_i | input | ADDR_W | Starting address of a burst |
| addr_o | output | ADDR_W | Address of the current beat |

## Verification
The bound checker tests these properties on every clock:
- a load from either strobe, including one that coincides with an advance, lands on `addr_o`;
- idle cycles hold the address;
- advances leave the upper bits alone;
- a linear advance adds one to the low bits;
- an interleaved advance always flips bit 0.

Some behaviour spans a whole burst, and only the bench scenarios can show it: the full interleaved sequence for each starting beat, the return to the start after four advances, and the zero address after reset. The scoreboard model covers these.

// File: rtl/burst_pkg.sv
// Package: shared types for the burst address generator.
// Assumes: only the two wraparound orders below exist.
package burst_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_t;
endpackage

// File: rtl/burst_start_reg.sv
// Module: burst_start_reg
// Holds the full starting address of the current burst.
// Assumes: the load request has already merged both strobes.
module burst_start_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] start_o
);
    logic [ADDR_W-1:0] start_q;

    // Capture the start address on a load and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (load_i) begin
            start_q <= addr_i;
        end
    end

    assign start_o = start_q;
endmodule

// File: rtl/burst_beat_ctr.sv
// Module: burst_beat_ctr
// Counts the beats taken since the last load, wrapping modulo 2**BEAT_W.
// Assumes: a load outranks an advance in the same cycle.
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    output logic [BEAT_W-1:0] beat_o
);
    logic [BEAT_W-1:0] beat_q;

    // Zero the count on reset or load, and step it on an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load_i) begin
            beat_q <= '0;
        end else if (adv_i) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign beat_o = beat_q;
endmodule

// File: rtl/burst_order_map.sv
// Module: burst_order_map
// Maps the start beat and the beat count to the low address bits.
// Linear order adds them; interleaved order XORs them per bit.
// Assumes: order_i is static for the length of a burst.
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  burst_order_t      order_i,
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [BEAT_W-1:0] low_o
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    // Linear order: modulo add that wraps within the group.
    assign lin_low = start_i + beat_i;

    // Interleaved order: one XOR per address bit.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_low[b] = start_i[b] ^ beat_i[b];
    end

    // Pick the order that the strap selects.
    always_comb begin
        if (order_i == ORD_INTERLEAVE) begin
            low_o = ilv_low;
        end else begin
            low_o = lin_low;
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Produces the address of each beat of a wraparound burst.
// Either strobe loads the start address, and adv_i moves to the next beat.
// Assumes: order_i is a static strap; the output is driven from registers only.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_cpu_i,
    input  logic              ld_ctl_i,
    input  logic              adv_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic              load;
    logic [ADDR_W-1:0] start_addr;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low_bits;
    burst_order_t      order_sel;

    // Merge the two start strobes into one load request.
    assign load      = ld_cpu_i | ld_ctl_i;
    assign order_sel = burst_order_t'(order_i);

    burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .addr_i  (addr_i),
        .start_o (start_addr)
    );

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .adv_i  (adv_i),
        .beat_o (beat)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .order_i (order_sel),
        .start_i (start_addr[BEAT_W-1:0]),
        .beat_i  (beat),
        .low_o   (low_bits)
    );

    // Join the frozen upper bits to the sequenced low bits.
    assign addr_o = {start_addr[ADDR_W-1 -: UPPER_W], low_bits};
endmodule

// File: rtl/burst_addr_gen_chk.sv
// Module: burst_addr_gen_chk
// Per-cycle checker for burst_addr_gen, attached with bind.
// Assumes: synchronous active-low reset; labels carry the requirement tag.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_cpu_i,
    input logic              ld_ctl_i,
    input logic              adv_i,
    input logic              order_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o
);
    assert_cpu_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cpu_i |=> addr_o == $past(addr_i));

    assert_ctl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ctl_i |=> addr_o == $past(addr_i));

    assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !ld_cpu_i && !ld_ctl_i && !order_i) |=>
        addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1));

    assert_ilv_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !ld_cpu_i && !ld_ctl_i && order_i) |=>
        addr_o[0] != $past(addr_o[0]));

    assert_upper_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !ld_cpu_i && !ld_ctl_i) |=>
        addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !ld_cpu_i && !ld_ctl_i) |=> $stable(addr_o));

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ld_cpu_i || ld_ctl_i) && adv_i) |=> addr_o == $past(addr_i));

    assert_dual_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_cpu_i && ld_ctl_i) |=> addr_o == $past(addr_i));

    assert_strap_static_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !ld_cpu_i && !ld_ctl_i) |-> order_i == $past(order_i));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_cpu_i (ld_cpu_i),
    .ld_ctl_i (ld_ctl_i),
    .adv_i    (adv_i),
    .order_i  (order_i),
    .addr_i   (addr_i),
    .addr_o   (addr_o)
);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard for burst_addr_gen.
// The driver queues the expected addresses; the monitor compares them after each edge.
module burst_addr_gen_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_cpu = 1'b0;
    logic          ld_ctl = 1'b0;
    logic          adv = 1'b0;
    logic          order = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] exp_q[$];
    string         tag_q[$];
    logic [AW-1:0] m_start = '0;
    logic [1:0]    m_beat = '0;

    burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u_burst_addr_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_cpu_i (ld_cpu),
        .ld_ctl_i (ld_ctl),
        .adv_i    (adv),
        .order_i  (order),
        .addr_i   (addr_in),
        .addr_o   (addr_out)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Compare one observed value with its expected value and count the result.
    task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the address expected after that edge.
    task automatic step(input bit lp, input bit lc, input bit ad,
                        input logic [AW-1:0] a, input string tag);
        logic [1:0] lo;
        @(negedge clk);
        ld_cpu = lp; ld_ctl = lc; adv = ad; addr_in = a;
        if (lp || lc) begin
            m_start = a;
            m_beat  = 2'd0;
        end else if (ad) begin
            m_beat = m_beat + 2'd1;
        end
        lo = order ? (m_start[1:0] ^ m_beat) : (m_start[1:0] + m_beat);
        exp_q.push_back({m_start[AW-1:2], lo});
        tag_q.push_back(tag);
    endtask

    // Change the strap between bursts, on an idle cycle.
    task automatic set_order(input bit o);
        @(negedge clk);
        ld_cpu = 0; ld_ctl = 0; adv = 0;
        order = o;
    endtask

    // Monitor: compare addr_o with the queue shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) check(addr_out, exp_q.pop_front(), tag_q.pop_front());
    end

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check(addr_out, '0, "R1 reset value");
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 16'h5555, "R1 idle after reset");

        set_order(0);
        step(1, 0, 0, 16'h1232, "R2 cpu load");
        step(0, 0, 1, 16'h0000, "R4 R6 linear beat 3");
        step(0, 0, 1, 16'h0000, "R4 linear beat 0");
        step(0, 0, 1, 16'h0000, "R4 linear beat 1");
        step(0, 0, 1, 16'h0000, "R8 linear wrap to start");
        step(0, 0, 0, 16'hFFFF, "R7 hold");
        step(0, 0, 0, 16'h0001, "R7 hold again");
        step(1, 0, 0, 16'h4443, "R2 cpu load start 3");
        step(0, 0, 1, 16'h0000, "R4 linear 3 to 0");
        step(0, 0, 1, 16'h0000, "R4 linear 0 to 1");

        set_order(1);
        step(0, 1, 0, 16'hABC1, "R3 ctl load");
        step(0, 0, 1, 16'h0000, "R5 interleave beat 0");
        step(0, 0, 1, 16'h0000, "R5 interleave beat 3");
        step(0, 0, 1, 16'h0000, "R5 R6 interleave beat 2");
        step(0, 0, 1, 16'h0000, "R8 interleave wrap");
        step(0, 0, 1, 16'h0000, "R8 second lap");
        step(0, 1, 0, 16'h00F2, "R3 ctl load start 2");
        step(0, 0, 1, 16'h0000, "R5 start 2 beat 3");
        step(0, 0, 1, 16'h0000, "R5 start 2 beat 0");
        step(0, 0, 1, 16'h0000, "R5 start 2 beat 1");
        step(1, 0, 1, 16'h0F03, "R9 load beats advance");
        step(0, 1, 1, 16'h0F00, "R9 ctl load beats advance");
        step(1, 1, 0, 16'h7772, "R10 both strobes");
        step(0, 0, 1, 16'h0000, "R5 after dual load");

        set_order(0);
        step(0, 0, 0, 16'h0000, "R11 strap change on idle");
        step(1, 1, 1, 16'hC0DE, "R10 R9 all asserted");
        step(0, 0, 1, 16'h0000, "R4 linear after dual load");

        @(negedge clk);
        ld_cpu = 0; ld_ctl = 0; adv = 0;
        repeat (3) @(posedge clk);
        #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule